// File: doc/BRIEF.md
# Host-to-Slave Byte Mailbox with Status Flags

This block passes bytes in both directions between an external host bus and an internal slave processor bus. The host writes a byte into an inbound data register, and the slave reads it. The slave writes a byte into an outbound data register, and the host reads it. A shared status word carries three flags. The inbound-full flag shows that the slave has unread input. The outbound-full flag shows that the host has unread output. The command/data flag records whether the last host write was a command or a data byte. While the inbound-full flag is set, an interrupt request to the slave is held high.

The host side is asynchronous. Its chip select, address line, read and write strobes and data byte pass through multi-flop synchronizers into the slave clock. All edge detection happens in that clock domain. Each flag changes on its own edge of its own strobe:

- A host write is taken when its strobe returns high.
- A host read is taken when its strobe returns high.
- A slave access is taken when its strobe drops.

When the host address line is high, a host read selects the status word and a host write delivers a command byte. When the address line is low, the host selects the data registers.

Top module: `host_mbox_status`

## Requirements
- R1: After reset, the status word reads 0 from both sides, s_irq is 0, and h_rdata is 0.
- R2: The rising edge of h_wr_n while h_cs_n is low captures h_wdata into the inbound register and sets inbound-full. This holds for either level of h_a0.
- R3: The falling edge of a slave read strobe with s_sel=0 (inbound data) clears inbound-full. A slave read with s_sel=1 (status) leaves all flags unchanged.
- R4: The falling edge of a slave write strobe with s_sel=0 sets outbound-full, and the written byte becomes the outbound data.
- R5: The rising edge of h_rd_n while h_cs_n is low and h_a0 is 0 clears outbound-full. A host status read (h_a0=1) leaves all flags unchanged.
- R6: Every accepted host write loads the command/data flag with the h_a0 level held during that write.
- R7: s_irq is 1 exactly while inbound-full is 1.
- R8: The status word has outbound-full at bit 0, inbound-full at bit 1 and command/data at bit 3, with every other bit 0. The slave reads it with s_sel=1, and the host reads it with h_a0=1.
- R9: When a set event and a clear event for the same flag fall in the same clock cycle, the flag ends up set.
- R10: Host strobes given while h_cs_n is high change neither the flags nor the data registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst | input | 1 | Synchronous active-high reset |
| h_cs_n | input | 1 | Host chip select, active low, asynchronous |
| h_a0 | input | 1 | Host address line: 0 selects data, 1 selects status or command |
| h_rd_n | input | 1 | Host read strobe, active low |
| h_wr_n | input | 1 | Host write strobe, active low |
| h_wdata | input | DATA_W | Host write byte |
| h_rdata | output | DATA_W | Host read byte (registered) |
| s_sel | input | 1 | Slave select: 0 selects data registers, 1 selects status |
| s_rd | input | 1 | Slave read strobe, active high |
| s_wr | input | 1 | Slave write strobe, active high |
| s_wdata | input | DATA_W | Slave write byte |
| s_rdata | output | DATA_W | Slave read byte (registered) |
| s_irq | output | 1 | Interrupt request to the slave |

## Verification
The bench builds the block with DATA_W=8 and SYNC_STAGES=2.

- The 8-bit width lets the bench sweep every byte value through both data directions, with the command/data level alternating between transfers.
- The two-stage synchronizer gives a fixed three-edge latency from a host strobe edge to a flag update. Knowing that latency, the bench can place a host write completion and a slave inbound read in the same clock cycle and check that the set wins.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int OBF_POS = 0;
  localparam int IBF_POS = 1;
  localparam int CD_POS  = 3;
  localparam int MIN_W   = CD_POS + 1;
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mbox_edge.sv
module mbox_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/host_mbox_status.sv
module host_mbox_status
  import mbox_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h_cs_n,
  input  logic              h_a0,
  input  logic              h_rd_n,
  input  logic              h_wr_n,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  input  logic              s_sel,
  input  logic              s_rd,
  input  logic              s_wr,
  input  logic [DATA_W-1:0] s_wdata,
  output logic [DATA_W-1:0] s_rdata,
  output logic              s_irq
);
  localparam int HV_W = DATA_W + 4;
  localparam logic [HV_W-1:0] HV_RST = {1'b1, 1'b0, 1'b1, 1'b1, {DATA_W{1'b0}}};

  initial begin
    if (DATA_W < MIN_W) $error("DATA_W too small for status layout");
  end

  // Host sample vector: {cs_n, a0, rd_n, wr_n, data}
  logic [HV_W-1:0] h_sync, h_last;

  mbox_sync #(.W(HV_W), .STAGES(SYNC_STAGES), .RST_VAL(HV_RST)) u_hsync (
    .clk (clk),
    .rst (rst),
    .d   ({h_cs_n, h_a0, h_rd_n, h_wr_n, h_wdata}),
    .q   (h_sync)
  );

  always_ff @(posedge clk) begin
    if (rst) h_last <= HV_RST;
    else     h_last <= h_sync;
  end

  logic              last_cs_n, last_a0;
  logic [DATA_W-1:0] last_data;
  assign last_cs_n = h_last[DATA_W+3];
  assign last_a0   = h_last[DATA_W+2];
  assign last_data = h_last[DATA_W-1:0];

  logic wr_rise, wr_fall_unused, rd_rise, rd_fall_unused;

  mbox_edge #(.RST_VAL(1'b1)) u_hwr_edge (
    .clk (clk), .rst (rst), .lvl (h_sync[DATA_W]),
    .rise (wr_rise), .fall (wr_fall_unused)
  );
  mbox_edge #(.RST_VAL(1'b1)) u_hrd_edge (
    .clk (clk), .rst (rst), .lvl (h_sync[DATA_W+1]),
    .rise (rd_rise), .fall (rd_fall_unused)
  );

  logic host_wr_ev, host_rd_ev;
  assign host_wr_ev = wr_rise & ~last_cs_n;
  assign host_rd_ev = rd_rise & ~last_cs_n & ~last_a0;

  // Slave strobes, qualified by the data-register select
  logic srd_rise_unused, slv_rd_ev, swr_rise_unused, slv_wr_ev;

  mbox_edge #(.RST_VAL(1'b0)) u_srd_edge (
    .clk (clk), .rst (rst), .lvl (s_rd & ~s_sel),
    .rise (srd_rise_unused), .fall (slv_rd_ev)
  );
  mbox_edge #(.RST_VAL(1'b0)) u_swr_edge (
    .clk (clk), .rst (rst), .lvl (s_wr & ~s_sel),
    .rise (swr_rise_unused), .fall (slv_wr_ev)
  );

  logic ibf, obf, cd;

  mbox_flag u_ibf (.clk (clk), .rst (rst), .set (host_wr_ev), .clr (slv_rd_ev), .q (ibf));
  mbox_flag u_obf (.clk (clk), .rst (rst), .set (slv_wr_ev),  .clr (host_rd_ev), .q (obf));

  logic [DATA_W-1:0] idr, odr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cd  <= 1'b0;
      idr <= '0;
      odr <= '0;
    end else begin
      if (host_wr_ev) begin
        cd  <= last_a0;
        idr <= last_data;
      end
      if (s_wr && !s_sel) odr <= s_wdata;
    end
  end

  logic [DATA_W-1:0] sts;
  always_comb begin
    sts          = '0;
    sts[OBF_POS] = obf;
    sts[IBF_POS] = ibf;
    sts[CD_POS]  = cd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_rdata <= '0;
      s_rdata <= '0;
    end else begin
      h_rdata <= last_a0 ? sts : odr;
      s_rdata <= s_sel ? sts : idr;
    end
  end

  assign s_irq = ibf;
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker (
  input logic clk,
  input logic rst,
  input logic host_wr_ev,
  input logic host_rd_ev,
  input logic slv_rd_ev,
  input logic slv_wr_ev,
  input logic last_a0,
  input logic ibf,
  input logic obf,
  input logic cd,
  input logic s_irq
);
  p_ibf_set_r2: assert property (@(posedge clk) disable iff (rst)
    host_wr_ev |=> ibf);

  p_ibf_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (slv_rd_ev && !host_wr_ev) |=> !ibf);

  p_obf_set_r4: assert property (@(posedge clk) disable iff (rst)
    slv_wr_ev |=> obf);

  p_obf_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (host_rd_ev && !slv_wr_ev) |=> !obf);

  p_cd_latch_r6: assert property (@(posedge clk) disable iff (rst)
    host_wr_ev |=> (cd == $past(last_a0)));

  p_irq_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(s_irq) |-> $past(host_wr_ev));

  p_ibf_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!host_wr_ev && !slv_rd_ev) |=> $stable(ibf));

  p_obf_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!slv_wr_ev && !host_rd_ev) |=> $stable(obf));
endmodule

bind host_mbox_status mbox_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_wr_ev (host_wr_ev),
  .host_rd_ev (host_rd_ev),
  .slv_rd_ev  (slv_rd_ev),
  .slv_wr_ev  (slv_wr_ev),
  .last_a0    (last_a0),
  .ibf        (ibf),
  .obf        (obf),
  .cd         (cd),
  .s_irq      (s_irq)
);

// File: tb/tb_host_mbox_status.sv
module tb_host_mbox_status;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic h_cs_n = 1'b1, h_a0 = 1'b0, h_rd_n = 1'b1, h_wr_n = 1'b1;
  logic [DW-1:0] h_wdata = '0;
  logic [DW-1:0] h_rdata;
  logic s_sel = 1'b0, s_rd = 1'b0, s_wr = 1'b0;
  logic [DW-1:0] s_wdata = '0;
  logic [DW-1:0] s_rdata;
  logic s_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  host_mbox_status #(.DATA_W(DW), .SYNC_STAGES(2)) dut (
    .clk (clk), .rst (rst),
    .h_cs_n (h_cs_n), .h_a0 (h_a0), .h_rd_n (h_rd_n), .h_wr_n (h_wr_n),
    .h_wdata (h_wdata), .h_rdata (h_rdata),
    .s_sel (s_sel), .s_rd (s_rd), .s_wr (s_wr),
    .s_wdata (s_wdata), .s_rdata (s_rdata), .s_irq (s_irq)
  );

  function automatic logic [DW-1:0] sts(input logic obf, input logic ibf, input logic cd);
    sts = '0;
    sts[0] = obf;
    sts[1] = ibf;
    sts[3] = cd;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic host_write(input logic cs_n, input logic a0, input logic [DW-1:0] d);
    @(negedge clk); h_cs_n = cs_n; h_a0 = a0; h_wdata = d;
    wait_n(2); h_wr_n = 1'b0;
    wait_n(3); h_wr_n = 1'b1;
    wait_n(4); h_cs_n = 1'b1;
    wait_n(4);
  endtask

  task automatic host_read(input logic cs_n, input logic a0, output logic [DW-1:0] q);
    @(negedge clk); h_cs_n = cs_n; h_a0 = a0;
    wait_n(2); h_rd_n = 1'b0;
    wait_n(5); q = h_rdata;
    h_rd_n = 1'b1;
    wait_n(4); h_cs_n = 1'b1;
    wait_n(4);
  endtask

  task automatic slave_read(input logic sel, output logic [DW-1:0] q);
    @(negedge clk); s_sel = sel; s_rd = 1'b1;
    @(negedge clk); q = s_rdata; s_rd = 1'b0;
    wait_n(3);
  endtask

  task automatic slave_write(input logic [DW-1:0] d);
    @(negedge clk); s_sel = 1'b0; s_wr = 1'b1; s_wdata = d;
    @(negedge clk); s_wr = 1'b0;
    wait_n(3);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : stim
    logic [DW-1:0] q;
    wait_n(4);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    check("R1 irq", s_irq, 0);
    check("R1 h_rdata", h_rdata, 0);
    slave_read(1'b1, q); check("R1 slave status", q, 0);
    host_read(1'b0, 1'b1, q); check("R1 host status", q, 0);

    // Inbound sweep: every byte, h_a0 alternating
    for (int v = 0; v < 256; v++) begin
      logic a;
      a = v[0] ^ v[4];
      host_write(1'b0, a, v[DW-1:0]);
      check("R7 irq set", s_irq, 1);
      slave_read(1'b1, q); check("R2 R6 R8 status after write", q, sts(1'b0, 1'b1, a));
      check("R3 status read keeps ibf", s_irq, 1);
      slave_read(1'b0, q); check("R2 inbound data", q, v);
      check("R7 irq clear", s_irq, 0);
      slave_read(1'b1, q); check("R3 ibf cleared", q, sts(1'b0, 1'b0, a));
    end

    // Outbound sweep: every byte
    for (int v = 0; v < 256; v++) begin
      slave_write(v[DW-1:0]);
      host_read(1'b0, 1'b1, q); check("R4 R8 host status obf", q[2:0], 3'b001);
      host_read(1'b0, 1'b1, q); check("R5 status read keeps obf", q[0], 1);
      host_read(1'b0, 1'b0, q); check("R4 outbound data", q, v);
      host_read(1'b0, 1'b1, q); check("R5 obf cleared", q[0], 0);
    end

    // R10: deselected host write and read
    host_write(1'b1, 1'b1, 8'hA5);
    check("R10 irq unchanged", s_irq, 0);
    slave_read(1'b0, q); check("R10 inbound data unchanged", q, 8'hFF);
    slave_write(8'h3C);
    host_read(1'b1, 1'b0, q);
    host_read(1'b0, 1'b1, q); check("R10 obf unchanged", q[0], 1);
    host_read(1'b0, 1'b0, q); check("R10 outbound data", q, 8'h3C);

    // R9: host write completes in the same cycle as slave inbound read falls
    @(negedge clk); h_cs_n = 1'b0; h_a0 = 1'b0; h_wdata = 8'h5A;
    wait_n(2); h_wr_n = 1'b0;
    wait_n(3); h_wr_n = 1'b1;
    @(negedge clk); s_sel = 1'b0; s_rd = 1'b1;
    @(negedge clk); s_rd = 1'b0;
    wait_n(3); h_cs_n = 1'b1;
    check("R9 set wins irq", s_irq, 1);
    slave_read(1'b1, q); check("R9 set wins status", q, sts(1'b0, 1'b1, 1'b0));
    slave_read(1'b0, q); check("R9 data captured", q, 8'h5A);
    check("R3 cleared after tie", s_irq, 0);

    // R1: reset in mid-state
    host_write(1'b0, 1'b1, 8'h11);
    slave_write(8'h22);
    @(negedge clk); rst = 1'b1;
    wait_n(3);
    @(negedge clk); rst = 1'b0;
    check("R1 irq after reset", s_irq, 0);
    slave_read(1'b1, q); check("R1 status after reset", q, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule